// File: doc/BRIEF.md
# Two-Wire Bus Slave Address Responder

This block is the slave-side front end of a two-wire serial bus (SMBus/I2C). It always watches the clock and data lines through synchronisers and finds START and STOP conditions. After a START it shifts in a 7-bit address and a direction bit, then compares the address with a programmed own address. On a match it pulls the data line low for the acknowledge clock, raises a sticky interrupt flag and keeps the direction bit. Any other outcome leaves the data line released, which is a NACK.

There are two controls. A global enable turns off all bus reactions. A slave-inhibit input makes the responder refuse every address while it keeps tracking bus conditions. The inhibit input is captured only when a START occurs, so the transfer in progress ends as it began. The block handles the address phase only. After the acknowledge it waits for the next START or STOP.

Top module: `smb_addr_responder`

## Requirements
- R1: After reset `sda_pull`, `irq` and `rw_bit` are all 0.
- R2: START is SDA falling while SCL is high. STOP is SDA rising while SCL is high. After a START the first eight SCL rising edges sample the address MSB first (seven address bits, then the direction bit, where 1 means read). Bits clocked after a STOP with no new START are never acknowledged.
- R3: When the address equals `own_addr` and the transfer is not inhibited, `sda_pull` goes to 1 after the SCL falling edge that follows the eighth rising edge. It returns to 0 after the SCL falling edge that ends the ninth clock, so the master reads 0 on SDA during the ninth clock.
- R4: An acknowledged address sets `irq` to 1 and loads `rw_bit` with the received direction bit. `irq` stays 1 until a pulse on `irq_clear`. `rw_bit` changes only when an acknowledge sets `irq`.
- R5: When the address differs from `own_addr`, SDA is never pulled and `irq` does not rise. Every further clock of that transfer is ignored until the next START or STOP.
- R6: When `inhibit` is 1 at the START, even a matching address gets a NACK and `irq` does not rise.
- R7: `inhibit` is sampled only at a START. A change during the transfer does not alter the outcome of that transfer.
- R8: While `enable` is 0 the block never pulls SDA and never sets `irq`. Lowering `enable` abandons the current transfer, and clocks that follow without a new START are not acknowledged.
- R9: A repeated START in the middle of an address restarts address reception from the first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Global enable for all bus reactions |
| inhibit | input | 1 | Slave inhibit, captured at each START |
| own_addr | input | ADDR_BITS | Programmed own slave address |
| irq_clear | input | 1 | Clears the interrupt flag |
| scl_in | input | 1 | SCL line level, asynchronous |
| sda_in | input | 1 | SDA line level, asynchronous |
| sda_pull | output | 1 | 1 pulls SDA low; 0 releases it (open drain) |
| irq | output | 1 | Sticky address-match interrupt flag |
| rw_bit | output | 1 | Direction bit of the last acknowledged address |

## Verification
The assertions assume that SCL and SDA each stay at one level for several system clocks, so that the synchronised copies show every edge, and that the master never moves SDA while SCL is high except to make a START or STOP. The bench drives the bus with a quarter-bit time of 20 system clocks and changes data only while SCL is low. It releases SDA during the acknowledge clock, which makes the line level the wired-AND of the master and the block. Controls such as `inhibit` and `enable` change only while SCL is low, away from any START.

// File: rtl/smb_pkg.sv
package smb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_WAIT,
    ST_ACK_DRIVE,
    ST_SKIP
  } slv_state_t;

endpackage

// File: rtl/smb_sync.sv
module smb_sync #(
  parameter int WIDTH     = 2,
  parameter int STAGES    = 2,
  parameter bit RESET_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] d_sync
);

  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) begin
          chain[s] <= {WIDTH{RESET_VAL}};
        end else if (s == 0) begin
          chain[s] <= d_async;
        end else begin
          chain[s] <= chain[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign d_sync = chain[STAGES-1];

endmodule

// File: rtl/smb_bus_events.sv
module smb_bus_events (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic start_p,
  output logic stop_p,
  output logic scl_rise,
  output logic scl_fall
);

  logic scl_q;
  logic sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  // Data-line edges that happen while the clock line stays high
  assign start_p  = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_p   = scl_s & scl_q & ~sda_q & sda_s;
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;

endmodule

// File: rtl/smb_addr_fsm.sv
module smb_addr_fsm
  import smb_pkg::*;
#(
  parameter int ADDR_BITS = 7
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 enable,
  input  logic                 inhibit,
  input  logic [ADDR_BITS-1:0] own_addr,
  input  logic                 irq_clear,
  input  logic                 sda_s,
  input  logic                 start_p,
  input  logic                 stop_p,
  input  logic                 scl_rise,
  input  logic                 scl_fall,
  output logic                 sda_pull,
  output logic                 irq,
  output logic                 rw_bit,
  output logic                 inh_lat
);

  localparam int BYTE_BITS = ADDR_BITS + 1;
  localparam int CNT_W     = $clog2(BYTE_BITS);

  slv_state_t           state;
  logic [CNT_W-1:0]     bit_cnt;
  logic [ADDR_BITS-1:0] shreg;
  logic [BYTE_BITS-1:0] byte_next;
  logic                 last_bit;
  logic                 hit;

  assign byte_next = {shreg, sda_s};
  assign last_bit  = (bit_cnt == CNT_W'(BYTE_BITS - 1));
  assign hit       = (byte_next[BYTE_BITS-1:1] == own_addr) && !inh_lat;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      shreg    <= '0;
      inh_lat  <= 1'b0;
      sda_pull <= 1'b0;
      irq      <= 1'b0;
      rw_bit   <= 1'b0;
    end else begin
      if (irq_clear) begin
        irq <= 1'b0;
      end
      if (!enable) begin
        state    <= ST_IDLE;
        bit_cnt  <= '0;
        sda_pull <= 1'b0;
      end else if (start_p) begin
        state    <= ST_ADDR;
        bit_cnt  <= '0;
        inh_lat  <= inhibit;
        sda_pull <= 1'b0;
      end else if (stop_p) begin
        state    <= ST_IDLE;
        sda_pull <= 1'b0;
      end else begin
        case (state)
          ST_ADDR: begin
            if (scl_rise) begin
              shreg <= byte_next[ADDR_BITS-1:0];
              if (last_bit) begin
                bit_cnt <= '0;
                if (hit) begin
                  state  <= ST_ACK_WAIT;
                  irq    <= 1'b1;
                  rw_bit <= byte_next[0];
                end else begin
                  state <= ST_SKIP;
                end
              end else begin
                bit_cnt <= bit_cnt + 1'b1;
              end
            end
          end
          ST_ACK_WAIT: begin
            if (scl_fall) begin
              sda_pull <= 1'b1;
              state    <= ST_ACK_DRIVE;
            end
          end
          ST_ACK_DRIVE: begin
            if (scl_fall) begin
              sda_pull <= 1'b0;
              state    <= ST_SKIP;
            end
          end
          default: begin
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/smb_addr_responder.sv
module smb_addr_responder #(
  parameter int ADDR_BITS   = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 enable,
  input  logic                 inhibit,
  input  logic [ADDR_BITS-1:0] own_addr,
  input  logic                 irq_clear,
  input  logic                 scl_in,
  input  logic                 sda_in,
  output logic                 sda_pull,
  output logic                 irq,
  output logic                 rw_bit
);

  logic [1:0] line_sync;
  logic       scl_s;
  logic       sda_s;
  logic       start_p;
  logic       stop_p;
  logic       scl_rise;
  logic       scl_fall;
  logic       inh_lat;

  smb_sync #(
    .WIDTH    (2),
    .STAGES   (SYNC_STAGES),
    .RESET_VAL(1'b1)
  ) i_sync (
    .clk    (clk),
    .rst    (rst),
    .d_async({scl_in, sda_in}),
    .d_sync (line_sync)
  );

  assign scl_s = line_sync[1];
  assign sda_s = line_sync[0];

  smb_bus_events i_events (
    .clk     (clk),
    .rst     (rst),
    .scl_s   (scl_s),
    .sda_s   (sda_s),
    .start_p (start_p),
    .stop_p  (stop_p),
    .scl_rise(scl_rise),
    .scl_fall(scl_fall)
  );

  smb_addr_fsm #(
    .ADDR_BITS(ADDR_BITS)
  ) i_fsm (
    .clk      (clk),
    .rst      (rst),
    .enable   (enable),
    .inhibit  (inhibit),
    .own_addr (own_addr),
    .irq_clear(irq_clear),
    .sda_s    (sda_s),
    .start_p  (start_p),
    .stop_p   (stop_p),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .sda_pull (sda_pull),
    .irq      (irq),
    .rw_bit   (rw_bit),
    .inh_lat  (inh_lat)
  );

endmodule

// File: rtl/smb_addr_checker.sv
module smb_addr_checker (
  input logic clk,
  input logic rst,
  input logic enable,
  input logic irq_clear,
  input logic sda_pull,
  input logic irq,
  input logic rw_bit,
  input logic scl_sync,
  input logic inh_lat
);

  // R3: the acknowledge pull starts only from a low clock phase
  assert_pull_rises_scl_low_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_pull) |-> !$past(scl_sync));

  // R4: the flag is sticky until cleared
  assert_irq_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    irq && !irq_clear |=> irq);

  // R4: direction bit moves only together with a set flag
  assert_rw_with_irq_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(rw_bit) |-> irq);

  // R6: an inhibited transfer neither acknowledges nor interrupts
  assert_inhibit_no_irq_R6: assert property (@(posedge clk) disable iff (rst)
    inh_lat |=> !$rose(irq));

  assert_inhibit_no_pull_R6: assert property (@(posedge clk) disable iff (rst)
    inh_lat |=> !$rose(sda_pull));

  // R8: disabled block stays off the bus and raises nothing
  assert_disabled_release_R8: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !sda_pull);

  assert_disabled_no_irq_R8: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !$rose(irq));

endmodule

bind smb_addr_responder smb_addr_checker i_chk (
  .clk      (clk),
  .rst      (rst),
  .enable   (enable),
  .irq_clear(irq_clear),
  .sda_pull (sda_pull),
  .irq      (irq),
  .rw_bit   (rw_bit),
  .scl_sync (scl_s),
  .inh_lat  (inh_lat)
);

// File: tb/test_smb_addr_responder.sv
module test_smb_addr_responder;

  localparam int ADDR_BITS = 7;
  localparam int QTR       = 20;
  localparam logic [6:0] OWN = 7'h5A;

  typedef struct {
    logic  ack;
    logic  irq;
    logic  rw;
    logic  pull_after;
    string req;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b1;
  logic inhibit = 1'b0;
  logic irq_clear = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_bus;
  logic sda_pull;
  logic irq;
  logic rw_bit;

  int checks = 0;
  int failures = 0;
  logic model_irq = 1'b0;
  logic model_rw = 1'b0;
  item_t exp_q[$];
  item_t obs_q[$];
  bit all_done = 1'b0;

  always #2.5 clk = ~clk;

  assign sda_bus = sda_m & ~sda_pull;

  smb_addr_responder #(.ADDR_BITS(ADDR_BITS), .SYNC_STAGES(2)) i_smb_addr_responder (
    .clk      (clk),
    .rst      (rst),
    .enable   (enable),
    .inhibit  (inhibit),
    .own_addr (OWN),
    .irq_clear(irq_clear),
    .scl_in   (scl_m),
    .sda_in   (sda_bus),
    .sda_pull (sda_pull),
    .irq      (irq),
    .rw_bit   (rw_bit)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic qwait();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; qwait();
    scl_m = 1'b1; qwait();
    sda_m = 1'b0; qwait();
    scl_m = 1'b0; qwait();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qwait();
    scl_m = 1'b1; qwait();
    sda_m = 1'b1; qwait();
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; qwait();
    scl_m = 1'b1; qwait(); qwait();
    scl_m = 1'b0; qwait();
  endtask

  // ninth clock: master releases SDA and reads the acknowledge
  task automatic ninth(output logic acked);
    sda_m = 1'b1; qwait();
    scl_m = 1'b1; qwait();
    acked = ~sda_bus;
    qwait();
    scl_m = 1'b0; qwait();
  endtask

  // mode: 0 plain, 1 toggle inhibit after 4 bits, 2 pulse enable low after 4 bits
  task automatic addr_phase(input logic [6:0] a, input logic rw, input bit do_start,
                            input int mode, input logic exp_ack, input string req);
    logic  acked;
    item_t e;
    item_t o;
    logic [7:0] b;
    b = {a, rw};
    if (do_start) bus_start();
    for (int i = 7; i >= 0; i--) begin
      send_bit(b[i]);
      if (i == 4 && mode == 1) inhibit = ~inhibit;
      if (i == 4 && mode == 2) begin
        enable = 1'b0; repeat (6) @(negedge clk); enable = 1'b1;
      end
    end
    ninth(acked);
    if (exp_ack) begin
      model_irq = 1'b1;
      model_rw  = rw;
    end
    e.ack = exp_ack; e.irq = model_irq; e.rw = model_rw; e.pull_after = 1'b0; e.req = req;
    exp_q.push_back(e);
    qwait();
    o.ack = acked; o.irq = irq; o.rw = rw_bit; o.pull_after = sda_pull; o.req = req;
    obs_q.push_back(o);
  endtask

  task automatic clear_irq(input string req);
    @(negedge clk) irq_clear = 1'b1;
    @(negedge clk) irq_clear = 1'b0;
    @(negedge clk);
    model_irq = 1'b0;
    check(irq == 1'b0, req, "irq after clear", irq, 0);
  endtask

  // monitor: compare results in the order the design produces them
  initial begin
    item_t e;
    item_t o;
    forever begin
      @(negedge clk);
      while (obs_q.size() > 0 && exp_q.size() > 0) begin
        e = exp_q.pop_front();
        o = obs_q.pop_front();
        check(o.ack == e.ack, e.req, "ack", o.ack, e.ack);
        check(o.irq == e.irq, e.req, "irq", o.irq, e.irq);
        check(o.rw == e.rw, e.req, "rw_bit", o.rw, e.rw);
        check(o.pull_after == e.pull_after, e.req, "sda_pull after ack clock",
              o.pull_after, e.pull_after);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!all_done) begin
      failures++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(sda_pull == 1'b0, "R1", "sda_pull", sda_pull, 0);
    check(irq == 1'b0, "R1", "irq", irq, 0);
    check(rw_bit == 1'b0, "R1", "rw_bit", rw_bit, 0);
    qwait();

    // R3 R4 matching write, then R2 matching read
    addr_phase(OWN, 1'b0, 1'b1, 0, 1'b1, "R3"); bus_stop();
    clear_irq("R4");
    check(rw_bit == 1'b0, "R4", "rw_bit held over clear", rw_bit, 0);
    addr_phase(OWN, 1'b1, 1'b1, 0, 1'b1, "R2"); bus_stop();
    clear_irq("R4");

    // R2 MSB-first: bit-reversed address must not match
    addr_phase(7'h2D, 1'b0, 1'b1, 0, 1'b0, "R2"); bus_stop();

    // R5 mismatch, then own address clocked without a START
    addr_phase(7'h11, 1'b0, 1'b1, 0, 1'b0, "R5");
    addr_phase(OWN, 1'b0, 1'b0, 0, 1'b0, "R5"); bus_stop();

    // R2 bits after STOP without START
    addr_phase(OWN, 1'b0, 1'b0, 0, 1'b0, "R2"); bus_stop();

    // R6 inhibited at START
    inhibit = 1'b1;
    addr_phase(OWN, 1'b0, 1'b1, 0, 1'b0, "R6"); bus_stop();

    // R7 inhibit raised mid-transfer: still acknowledged
    inhibit = 1'b0;
    addr_phase(OWN, 1'b1, 1'b1, 1, 1'b1, "R7"); bus_stop();
    clear_irq("R7");
    // R7 inhibit lowered mid-transfer: still refused
    addr_phase(OWN, 1'b0, 1'b1, 1, 1'b0, "R7"); bus_stop();
    check(inhibit == 1'b0, "R7", "inhibit level", inhibit, 0);

    // R8 disabled for a whole transfer
    enable = 1'b0;
    addr_phase(OWN, 1'b0, 1'b1, 0, 1'b0, "R8"); bus_stop();
    enable = 1'b1;
    // R8 enable dropped mid-address abandons the transfer
    addr_phase(OWN, 1'b0, 1'b1, 2, 1'b0, "R8"); bus_stop();

    // R9 repeated START after three stray bits
    bus_start();
    send_bit(1'b0); send_bit(1'b0); send_bit(1'b1);
    addr_phase(OWN, 1'b1, 1'b1, 0, 1'b1, "R9"); bus_stop();
    clear_irq("R9");

    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "R2", "unmatched expected items", exp_q.size(), 0);
    all_done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule